// File: doc/BRIEF.md
# Cold-Start Carry Flag

This block lets boot firmware decide, right after a reset, whether the supply actually dropped (a cold start) or whether only the chip-enable reset was pulsed (a warm start). In a cold start the firmware must initialize memory and output ports. In a warm start it can keep them. A free-running base timer divides the system clock and emits a one-cycle carry pulse each time it wraps. Each rising edge of that pulse sets a sticky carry flag.

The flag only becomes active after software has read it once. A power-on-clear input arms a one-shot lock, which keeps the flag at 0 until that first read. As a result, a flag of 0 at boot means the supply collapsed, and a flag of 1 means the timer has been running since software last looked.

The chip-enable reset does not disturb the flag, the lock or the timer. While chip-enable reset is active, read strobes are ignored, because the processor cannot execute reads then. Each effective read returns the present flag value and clears the flag on the same strobe.

Top module: `pwr_fail_flag`

## Requirements
- R1: While power-on-clear is high, and on the first samples after it is released, the flag output reads 0 and the carry output is 0.
- R2: After power-on-clear, carry pulses do not set the flag until the first effective read has been performed.
- R3: The first effective read (read strobe high while chip-enable reset is inactive) releases the lock permanently, until the next power-on-clear.
- R4: Once the lock is released, a rising edge of the carry pulse sets the flag to 1 at the next clock edge. The flag stays at 1 until it is read.
- R5: The flag output always presents the current flag value. An effective read without a simultaneous carry edge clears the flag to 0 at that clock edge.
- R6: When a carry edge and an effective read arrive in the same cycle, the flag ends at 1 if the lock was already released before that read. It ends at 0 if that read is the one that releases the lock.
- R7: While chip-enable reset (active-low) is 0, read strobes have no effect on the flag or the lock. Carry pulses continue and still set a released flag.
- R8: The carry output is high for exactly one clock, once every 2^TIMER_BITS clocks.
- R9: Power-on-clear is asynchronous on assertion: a flag of 1 reads 0 by the first falling clock edge after power-on-clear rises. Release is synchronized, and the first carry pulse is visible SYNC_STAGES + 2^TIMER_BITS falling edges after power-on-clear falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_clr | input | 1 | Power-on-clear, active high, asynchronous assertion |
| ce_rst_n | input | 1 | Chip-enable reset, active low; blocks reads only |
| rd_stb | input | 1 | Flag read strobe, one clock per read |
| rd_flag_o | output | 1 | Current carry flag value (read data) |
| carry_o | output | 1 | One-clock carry pulse from the base timer |

## Verification
A carry pulse is observed on the carry output one clock after the timer reaches terminal count. Its effect on the flag appears at the next clock edge. A read changes the flag at the clock edge that samples the strobe. The bench drives and samples on falling edges: it waits until it sees the carry output high, then checks the flag one falling edge later. It checks a read one falling edge after the strobe was applied. Read vectors are placed right after a carry, so no timer wrap can fall inside a read window unless a test collides them on purpose. The power-on-clear release latency is counted in falling edges from release to the first visible pulse.

// File: rtl/pf_pkg.sv
// Shared constants for the cold-start carry flag.
// Assumes: all users run in one clock domain.
package pf_pkg;
    localparam int unsigned DEF_TIMER_BITS  = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Flag storage kept as one record so reset values sit in one place.
    typedef struct packed {
        logic locked;   // 1: carry edges may not set the flag
        logic flag;     // sticky carry flag
        logic carry_d;  // previous carry level for edge detect
    } flag_state_t;

    localparam flag_state_t FLAG_RESET = '{locked: 1'b1, flag: 1'b0, carry_d: 1'b0};
endpackage

// File: rtl/pf_por_sync.sv
// Power-on-clear conditioner: asserts the internal active-low reset at once
// when por_clr_i rises, and releases it only after STAGES clock edges.
// Assumes: STAGES >= 2; the clock runs while power-on-clear is active.
module pf_por_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic por_clr_i,
    output logic por_n_o
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain asynchronously.
    always_ff @(posedge clk_i or posedge por_clr_i) begin
        if (por_clr_i) chain_q <= '0;
        else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign por_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_base_timer.sv
// Free-running base timer: counts clocks modulo 2^BITS and emits a registered
// one-clock carry pulse each time the count passes its terminal value.
// Assumes: synchronous active-low reset from the power-on-clear conditioner.
module pf_base_timer #(
    parameter int unsigned BITS = 16
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic carry_o
);
    localparam logic [BITS-1:0] TERM = '1;

    logic [BITS-1:0] count_q;
    logic            carry_q;

    // Advance the prescaler every clock; restart it on power-on-clear.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) count_q <= '0;
        else          count_q <= count_q + 1'b1;
    end

    // Register the terminal-count strobe as the carry pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) carry_q <= 1'b0;
        else          carry_q <= (count_q == TERM);
    end

    assign carry_o = carry_q;

    // R8: the carry pulse never lasts longer than one clock.
    p_carry_one_clock_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        carry_q |=> !carry_q);
endmodule

// File: rtl/pf_carry_flag.sv
// Sticky carry flag with a one-shot lock. Power-on-clear sets the lock and
// clears the flag; the first effective read drops the lock; after that each
// rising carry edge sets the flag, and each read clears it (carry wins).
// Assumes: carry_i is synchronous to clk_i; ce_rst_n_i gates reads only.
module pf_carry_flag
    import pf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic ce_rst_n_i,
    input  logic rd_stb_i,
    input  logic carry_i,
    output logic flag_o
);
    flag_state_t st_q;
    logic        rd_eff;
    logic        rise;

    assign rd_eff = rd_stb_i & ce_rst_n_i;
    assign rise   = carry_i & ~st_q.carry_d;

    // Update lock, flag and edge history; lock state before the read decides.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q <= FLAG_RESET;
        end else begin
            st_q.carry_d <= carry_i;
            if (rd_eff) st_q.locked <= 1'b0;
            if (rise && !st_q.locked) st_q.flag <= 1'b1;
            else if (rd_eff)          st_q.flag <= 1'b0;
        end
    end

    assign flag_o = st_q.flag;

    // R2: a locked flag stays clear.
    p_locked_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        st_q.locked |=> !st_q.flag);
    // R3: an effective read releases the lock.
    p_read_unlocks_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rd_eff |=> !st_q.locked);
    // R3: once released, the lock stays released until power-on-clear.
    p_unlock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !st_q.locked |=> !st_q.locked);
    // R4 and R6: an edge on an unlocked flag sets it, read or not.
    p_edge_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rise && !st_q.locked) |=> st_q.flag);
    // R5: a read without a carry edge clears the flag.
    p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_eff && !rise) |=> !st_q.flag);
    // R7: while chip-enable reset is active and no edge arrives, nothing moves.
    p_ce_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ce_rst_n_i && !rise) |=> ($stable(st_q.flag) && $stable(st_q.locked)));
endmodule

// File: rtl/pwr_fail_flag.sv
// Top level of the cold-start carry flag: conditions power-on-clear, runs the
// base timer and holds the lockable carry flag read by boot firmware.
// Assumes: one clock domain; por_clr is the only asynchronous input.
module pwr_fail_flag
    import pf_pkg::*;
#(
    parameter int unsigned TIMER_BITS  = DEF_TIMER_BITS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic por_clr,
    input  logic ce_rst_n,
    input  logic rd_stb,
    output logic rd_flag_o,
    output logic carry_o
);
    logic por_n;
    logic carry;

    pf_por_sync #(.STAGES(SYNC_STAGES)) u_por (
        .clk_i     (clk),
        .por_clr_i (por_clr),
        .por_n_o   (por_n)
    );

    pf_base_timer #(.BITS(TIMER_BITS)) u_timer (
        .clk_i   (clk),
        .rst_n_i (por_n),
        .carry_o (carry)
    );

    pf_carry_flag u_flag (
        .clk_i      (clk),
        .rst_n_i    (por_n),
        .ce_rst_n_i (ce_rst_n),
        .rd_stb_i   (rd_stb),
        .carry_i    (carry),
        .flag_o     (rd_flag_o)
    );

    assign carry_o = carry;
endmodule

// File: tb/pwr_fail_flag_bench.sv
module pwr_fail_flag_bench;
    localparam int TB_BITS = 4;
    localparam int TB_SYNC = 2;
    localparam int PERIOD  = 1 << TB_BITS;

    localparam logic [1:0] OP_IDLE  = 2'd0;
    localparam logic [1:0] OP_READ  = 2'd1;
    localparam logic [1:0] OP_CARRY = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic       ce_n;
        logic       exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{OP_IDLE,  1'b1, 1'b0},  // R1 fresh after power-on-clear
        '{OP_CARRY, 1'b1, 1'b0},  // R2 locked
        '{OP_CARRY, 1'b1, 1'b0},  // R2 still locked
        '{OP_READ,  1'b1, 1'b0},  // R3 first read unlocks
        '{OP_CARRY, 1'b1, 1'b1},  // R4 sets
        '{OP_IDLE,  1'b1, 1'b1},  // R4 sticky
        '{OP_READ,  1'b1, 1'b0},  // R5 clears
        '{OP_CARRY, 1'b1, 1'b1},  // R4
        '{OP_READ,  1'b0, 1'b1},  // R7 read ignored
        '{OP_CARRY, 1'b0, 1'b1},  // R7 carry still counts
        '{OP_READ,  1'b1, 1'b0},  // R5
        '{OP_CARRY, 1'b0, 1'b1}   // R7 set during chip-enable reset
    };

    logic clk = 1'b0;
    logic por_clr = 1'b1;
    logic ce_rst_n = 1'b1;
    logic rd_stb = 1'b0;
    logic rd_flag_o;
    logic carry_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_fail_flag #(.TIMER_BITS(TB_BITS), .SYNC_STAGES(TB_SYNC)) u_pwr_fail_flag (
        .clk       (clk),
        .por_clr   (por_clr),
        .ce_rst_n  (ce_rst_n),
        .rd_stb    (rd_stb),
        .rd_flag_o (rd_flag_o),
        .carry_o   (carry_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Step falling edges until the carry output is seen high (bounded).
    task automatic wait_carry();
        for (int i = 0; i < 4 * PERIOD; i++) begin
            @(negedge clk);
            if (carry_o === 1'b1) return;
        end
        check("R8 carry never seen", 0, 1);
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic power_on();
        @(negedge clk);
        por_clr = 1'b1;
        repeat (3) @(negedge clk);
        por_clr = 1'b0;
        repeat (TB_SYNC + 1) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 flag in power-on-clear", rd_flag_o, 0);
        check("R1 carry in power-on-clear", carry_o, 0);

        // R9: release latency in falling edges to the first visible carry.
        por_clr = 1'b0;
        n = 0;
        for (int i = 0; i < 4 * PERIOD; i++) begin
            @(negedge clk);
            n++;
            if (carry_o === 1'b1) break;
        end
        check("R9 release latency", n, TB_SYNC + PERIOD);

        // R8: pulse width and period.
        @(negedge clk);
        check("R8 pulse width", carry_o, 0);
        n = 1;
        for (int i = 0; i < 4 * PERIOD; i++) begin
            @(negedge clk);
            n++;
            if (carry_o === 1'b1) break;
        end
        check("R8 period", n, PERIOD);

        // Table walk from a fresh power-on-clear.
        power_on();
        for (int v = 0; v < NV; v++) begin
            ce_rst_n = VECS[v].ce_n;
            case (VECS[v].op)
                OP_READ:  do_read();
                OP_CARRY: begin wait_carry(); @(negedge clk); end
                default:  @(negedge clk);
            endcase
            check($sformatf("vector %0d (R1..R7 table)", v), rd_flag_o, VECS[v].exp);
        end
        ce_rst_n = 1'b1;

        // R6: unlocked flag at 0, read collides with carry edge -> ends at 1.
        do_read();
        check("R6 pre-clear", rd_flag_o, 0);
        wait_carry();
        do_read();
        check("R6 collision unlocked", rd_flag_o, 1);

        // R9: asynchronous power-on-clear clears a set flag by next falling edge.
        #1 por_clr = 1'b1;
        @(negedge clk);
        check("R9 async clear", rd_flag_o, 0);
        repeat (2) @(negedge clk);
        por_clr = 1'b0;
        repeat (TB_SYNC + 1) @(negedge clk);

        // R6: first (unlocking) read collides with carry edge -> ends at 0.
        wait_carry();
        do_read();
        check("R6 collision locked", rd_flag_o, 0);
        wait_carry();
        @(negedge clk);
        check("R3 unlocked by collided read", rd_flag_o, 1);

        // R2 again: a fresh cold start stays at 0 across carries.
        power_on();
        wait_carry();
        @(negedge clk);
        check("R2 cold start", rd_flag_o, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule